// File: doc/BRIEF.md
# Audio Channel Volume PWM Generator

This block sets the loudness of a single audio channel by pulse-width modulation. A host writes a 7-bit volume word into a volume register. The channel sequencer decides when that setting takes effect by pulsing a reload strobe, which copies the register into a separate level latch. A phase counter steps once per output tick through a period of 64 phases. A gate stays open for as many phases of each period as the latched level, and the channel's signed sample passes to the output only while the gate is open.

The counter does not run freely. A reload restarts it, and so does a data write from the host. At the restart the gate opens only when the latched level is nonzero and the channel is not attached to a neighbour as a period or volume modulator. A data load from the DMA path does not reach this block and does not restart anything. The gated output is a register that changes only on a tick.

Top module: `chan_vol_pwm`

## Requirements
- R1: A volume write stores the decoded level: when bit 6 of the word is 1 the level is 64, and otherwise it is the value of bits 5:0. The level therefore ranges from 0 to 64.
- R2: A volume write on its own does not change the level that drives the gate. The latch takes the register value only on a reload. When a write and a reload fall in the same cycle, the latch takes the register value from before that write.
- R3: A reload sets the phase to 0. In the cycle after it, the gate is 1 exactly when the newly latched level is nonzero and both attach flags are low.
- R4: Each tick advances the phase by one. The gate closes on the tick that brings the phase equal to the latched level. Nothing other than a restart opens the gate. From a restart, the gate is open before exactly L of the next 64 ticks, where L is the latched level (0 to 64).
- R5: On the tick that would take the phase to 64, the phase restarts at 0 and the gate reopens by the rule in R3.
- R6: A host data write restarts the phase using the level already in the latch, and the gate is then set by the rule in R3.
- R7: While attach_period or attach_volume is high, a restart leaves the gate closed.
- R8: On each tick, sample_out takes sample_in if the gate was 1 in that cycle, and 0 otherwise. Between ticks sample_out holds its value.
- R9: A synchronous reset clears the volume register, the latch, the phase and the gate, and sets sample_out to 0. A reload after reset with no volume write leaves the gate at 0.
- R10: When a restart (reload or host data write) and a tick fall in the same cycle, the restart wins. The phase becomes 0 and the tick does not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vol_wr | input | 1 | Host write strobe for the volume register |
| vol_word | input | 7 | Volume word written by the host |
| reload | input | 1 | Reload strobe from the channel sequencer |
| host_data_wr | input | 1 | Host write to the channel's data register |
| attach_period | input | 1 | Channel is attached as a period modulator |
| attach_volume | input | 1 | Channel is attached as a volume modulator |
| tick | input | 1 | Output tick enable |
| sample_in | input | 8 | Signed channel sample |
| gate | output | 1 | PWM gate |
| sample_out | output | 8 | Registered gated sample |

## Verification
The case hardest to reach from the ports is the one where the volume register and the latched level differ while the gate pattern is observed. The stimulus writes a new volume and then restarts the phase with a host data write instead of a reload. The gate count over a full period must then follow the old level. A reload with a same-cycle write must also latch the old value. The bench sweeps all 128 volume words, counting open gate phases over a whole period each time, and checks the gate and sample_out against an arithmetic model in every cycle.

// File: rtl/cvp_pkg.sv
package cvp_pkg;
    localparam int unsigned CVP_LOG2   = 6;
    localparam int unsigned CVP_PERIOD = 1 << CVP_LOG2;
    localparam int unsigned CVP_LVL_W  = CVP_LOG2 + 1;
    localparam int unsigned CVP_SMP_W  = 8;

    typedef logic [CVP_LVL_W-1:0]        lvl_t;
    typedef logic signed [CVP_SMP_W-1:0] smp_t;

    // Restart request seen by the phase counter
    typedef struct packed {
        logic restart;   // reload or host data write
        logic suppress;  // any attach mode active
    } rst_req_t;

    localparam lvl_t LVL_FULL   = lvl_t'(CVP_PERIOD);
    localparam lvl_t PHASE_LAST = lvl_t'(CVP_PERIOD - 1);

    function automatic lvl_t decode_level(input lvl_t word);
        if (word[CVP_LOG2])
            return LVL_FULL;
        return {1'b0, word[CVP_LOG2-1:0]};
    endfunction
endpackage

// File: rtl/cvp_level_store.sv
module cvp_level_store
    import cvp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vol_wr,
    input  lvl_t vol_word,
    input  logic reload,
    output lvl_t level_q,
    output lvl_t level_next
);
    lvl_t reg_q;

    // The latch takes the register value from before any same-cycle write
    assign level_next = reload ? reg_q : level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q   <= '0;
            level_q <= '0;
        end else begin
            if (vol_wr)
                reg_q <= decode_level(vol_word);
            level_q <= level_next;
        end
    end

    p_reg_range_r1: assert property (@(posedge clk) disable iff (rst)
        reg_q <= LVL_FULL);

    p_latch_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !reload |=> $stable(level_q));

    p_latch_copy_r2: assert property (@(posedge clk) disable iff (rst)
        reload |=> level_q == $past(reg_q));
endmodule

// File: rtl/cvp_phase_gate.sv
module cvp_phase_gate
    import cvp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  rst_req_t req,
    input  lvl_t     level_q,
    input  lvl_t     level_next,
    output logic     gate
);
    lvl_t phase_q;
    lvl_t phase_inc;
    logic wrap;

    assign phase_inc = phase_q + lvl_t'(1);
    assign wrap      = tick && (phase_q == PHASE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            gate    <= 1'b0;
        end else if (req.restart || wrap) begin
            phase_q <= '0;
            gate    <= (level_next != '0) && !req.suppress;
        end else if (tick) begin
            phase_q <= phase_inc;
            if (phase_inc == level_q)
                gate <= 1'b0;
        end
    end

    p_phase_range_r4: assert property (@(posedge clk) disable iff (rst)
        phase_q <= PHASE_LAST);

    p_restart_zero_r10: assert property (@(posedge clk) disable iff (rst)
        req.restart |=> phase_q == '0);

    p_gate_open_r3: assert property (@(posedge clk) disable iff (rst)
        req.restart |=> gate == ((level_q != '0) && !$past(req.suppress)));

    p_no_reopen_r4: assert property (@(posedge clk) disable iff (rst)
        (!req.restart && !wrap) |=> !$rose(gate));

    p_attach_closed_r7: assert property (@(posedge clk) disable iff (rst)
        (req.restart && req.suppress) |=> !gate);
endmodule

// File: rtl/cvp_out_stage.sv
module cvp_out_stage
    import cvp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic gate,
    input  smp_t sample_in,
    output smp_t sample_out
);
    always_ff @(posedge clk) begin
        if (rst)
            sample_out <= '0;
        else if (tick)
            sample_out <= gate ? sample_in : '0;
    end

    p_out_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && !gate) |=> sample_out == '0);

    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(sample_out));
endmodule

// File: rtl/chan_vol_pwm.sv
module chan_vol_pwm
    import cvp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vol_wr,
    input  logic [6:0] vol_word,
    input  logic       reload,
    input  logic       host_data_wr,
    input  logic       attach_period,
    input  logic       attach_volume,
    input  logic       tick,
    input  logic [7:0] sample_in,
    output logic       gate,
    output logic [7:0] sample_out
);
    lvl_t     level_q;
    lvl_t     level_next;
    rst_req_t req;
    smp_t     smp_q;

    assign req.restart  = reload || host_data_wr;
    assign req.suppress = attach_period || attach_volume;

    cvp_level_store u_store (
        .clk        (clk),
        .rst        (rst),
        .vol_wr     (vol_wr),
        .vol_word   (lvl_t'(vol_word)),
        .reload     (reload),
        .level_q    (level_q),
        .level_next (level_next)
    );

    cvp_phase_gate u_phase (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .req        (req),
        .level_q    (level_q),
        .level_next (level_next),
        .gate       (gate)
    );

    cvp_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .gate       (gate),
        .sample_in  (smp_t'(sample_in)),
        .sample_out (smp_q)
    );

    assign sample_out = smp_q;

    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> (!gate && sample_out == 8'd0));
endmodule

// File: tb/sim_chan_vol_pwm.sv
`timescale 1ns/1ps
module sim_chan_vol_pwm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vol_wr = 1'b0;
    logic [6:0] vol_word = '0;
    logic       reload = 1'b0;
    logic       host_data_wr = 1'b0;
    logic       attach_period = 1'b0;
    logic       attach_volume = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] sample_in = '0;
    logic       gate;
    logic [7:0] sample_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    chan_vol_pwm u0 (.*);

    // Arithmetic reference built from the requirements
    int m_reg = 0, m_lat = 0, m_phase = 0, m_out = 0;
    bit m_gate = 1'b0;

    function automatic int dec(input logic [6:0] w);
        return w[6] ? 64 : int'(w[5:0]);
    endfunction

    always @(posedge clk) begin
        int nlat;
        cyc <= cyc + 1;
        if (rst) begin
            m_reg = 0; m_lat = 0; m_phase = 0; m_gate = 1'b0; m_out = 0;
        end else begin
            nlat = reload ? m_reg : m_lat;
            if (vol_wr) m_reg = dec(vol_word);
            if (tick) m_out = m_gate ? int'(sample_in) : 0;
            if (reload || host_data_wr || (tick && m_phase == 63)) begin
                m_phase = 0;
                m_gate = (nlat != 0) && !attach_period && !attach_volume;
            end else if (tick) begin
                m_phase = m_phase + 1;
                if (m_phase == m_lat) m_gate = 1'b0;
            end
            m_lat = nlat;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Every-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(gate == m_gate, "R4 gate vs model", int'(gate), int'(m_gate));
            chk(int'(sample_out) == m_out, "R8 sample_out vs model",
                int'(sample_out), m_out);
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        sample_in = sample_in + 8'd37;
    endtask

    task automatic write_vol(input logic [6:0] w);
        vol_wr = 1'b1; vol_word = w; step(); vol_wr = 1'b0;
    endtask

    task automatic do_reload();
        reload = 1'b1; step(); reload = 1'b0;
    endtask

    task automatic run_ticks(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cnt += int'(gate);
            step();
        end
        tick = 1'b0;
    endtask

    initial begin
        int cnt;
        int lvl;
        repeat (3) step();
        rst = 1'b0;
        chk(gate == 1'b0, "R9 gate after reset", int'(gate), 0);
        chk(sample_out == 8'd0, "R9 sample_out after reset", int'(sample_out), 0);
        do_reload();
        chk(gate == 1'b0, "R9 reload with cleared register", int'(gate), 0);

        // Sweep of every volume word
        for (int w = 0; w < 128; w++) begin
            lvl = dec(7'(w));
            write_vol(7'(w));
            do_reload();
            chk(gate == (lvl != 0), "R3 gate after reload", int'(gate), int'(lvl != 0));
            run_ticks(64, cnt);
            chk(cnt == lvl, "R1 R4 open phases per period", cnt, lvl);
            chk(gate == (lvl != 0), "R5 reopen at wrap", int'(gate), int'(lvl != 0));
        end

        // R2: write without reload keeps old level
        write_vol(7'd5); do_reload();
        write_vol(7'd50);
        host_data_wr = 1'b1; step(); host_data_wr = 1'b0;
        run_ticks(64, cnt);
        chk(cnt == 5, "R2 write without reload", cnt, 5);
        // R2: same-cycle write and reload latches the old register value
        vol_wr = 1'b1; vol_word = 7'd20; reload = 1'b1; step();
        vol_wr = 1'b0; reload = 1'b0;
        run_ticks(64, cnt);
        chk(cnt == 50, "R2 same-cycle write and reload", cnt, 50);
        do_reload();
        run_ticks(64, cnt);
        chk(cnt == 20, "R2 later reload takes new value", cnt, 20);

        // R6: host data write restarts mid-period
        write_vol(7'd10); do_reload();
        run_ticks(20, cnt);
        chk(gate == 1'b0, "R6 gate closed before data write", int'(gate), 0);
        host_data_wr = 1'b1; step(); host_data_wr = 1'b0;
        chk(gate == 1'b1, "R6 data write reopens gate", int'(gate), 1);
        run_ticks(64, cnt);
        chk(cnt == 10, "R6 full period after data write", cnt, 10);

        // R7: attach modes keep the gate closed
        write_vol(7'd30);
        attach_period = 1'b1; do_reload();
        chk(gate == 1'b0, "R7 attach_period restart", int'(gate), 0);
        run_ticks(64, cnt);
        chk(cnt == 0, "R7 attach_period period", cnt, 0);
        attach_period = 1'b0; attach_volume = 1'b1;
        host_data_wr = 1'b1; step(); host_data_wr = 1'b0;
        chk(gate == 1'b0, "R7 attach_volume restart", int'(gate), 0);
        attach_volume = 1'b0;
        host_data_wr = 1'b1; step(); host_data_wr = 1'b0;
        chk(gate == 1'b1, "R7 released attach", int'(gate), 1);

        // R10: restart and tick together
        write_vol(7'd3); do_reload();
        run_ticks(2, cnt);
        reload = 1'b1; tick = 1'b1; step(); reload = 1'b0; tick = 1'b0;
        chk(gate == 1'b1, "R10 gate after reload with tick", int'(gate), 1);
        run_ticks(64, cnt);
        chk(cnt == 3, "R10 tick ignored on restart", cnt, 3);
        run_ticks(1, cnt);
        host_data_wr = 1'b1; tick = 1'b1; step(); host_data_wr = 1'b0; tick = 1'b0;
        run_ticks(64, cnt);
        chk(cnt == 3, "R10 data write with tick", cnt, 3);

        // R8: hold between ticks
        write_vol(7'd64); do_reload();
        sample_in = 8'h85; tick = 1'b1; @(posedge clk); #1; tick = 1'b0;
        chk(sample_out == 8'h85, "R8 passes sample", int'(sample_out), 'h85);
        repeat (5) step();
        chk(sample_out == 8'h85, "R8 holds between ticks", int'(sample_out), 'h85);

        // R9: reset mid-run
        rst = 1'b1; step(); rst = 1'b0;
        chk(gate == 1'b0 && sample_out == 8'd0, "R9 reset mid-run",
            int'(gate), 0);
        do_reload();
        chk(gate == 1'b0, "R9 register cleared by reset", int'(gate), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule